// File: doc/BRIEF.md
# Reload Down-Counter Timer with Terminal-Count Pulse

This block is a small timer that counts down from a value written over a byte-wide register bus. It runs in a fast system clock domain. It advances only on cycles where a single-cycle enable, derived from a slow (about 32 kHz) time base, is high. Each time the count reaches zero, the terminal-count output goes high for one tick interval. For a loaded value N, the output is low for N tick intervals and high for one, so its period is N+1 intervals.

Three registers are visible on the bus. A control register holds a run bit and a single-cycle mode bit. Two count registers together hold the 13-bit reload value. In repeating mode the counter reloads itself after every zero and keeps going. In single-cycle mode it stops after one full cycle and clears its own run bit. Software can see that the run bit has cleared and start the timer again by writing the run bit to 1.

Top module: `rtimer_top`

## Requirements
- R1: After reset every register reads zero and the terminal-count output is low.
- R2: The bus reads back three registers. Address 0 is control: bit 0 is the run bit, bit 1 is the single-cycle mode bit, and bits 7:2 read zero. Address 1 holds count bits 7:0. Address 2 holds count bits 12:8 in its bits 4:0, and bits 7:5 read zero. Address 3 reads zero. Writes take effect at the clock edge on which the write strobe is high.
- R3: On the first tick after the run bit becomes 1, the counter loads the 13-bit value held in the count registers. On that tick the output goes low, or goes high if the loaded value is zero.
- R4: Timer state and the terminal-count output change only on tick cycles. Between ticks they hold, so a high pulse lasts one whole tick interval.
- R5: With a loaded value N, the output is high only on the tick at which the count reaches zero, N ticks after loading.
- R6: In repeating mode, the tick after zero reloads the value, so the output has a period of N+1 ticks.
- R7: In single-cycle mode, the tick after the high pulse drives the output low and clears the run bit. The output then stays low, and control reads back with bit 0 at 0.
- R8: Writing the run bit to 1 after a single-cycle completion repeats the same N+1 tick sequence.
- R9: Writing the run bit to 0 stops the timer. The output is low at the clock edge of that write, and it stays low on the ticks that follow.
- R10: If the hardware self-clear and a bus write of run bit 1 fall on the same edge, the write wins. The run bit stays 1 and the timer reloads on the next tick.
- R11: A loaded value of zero in repeating mode keeps the output high on every tick.
- R12: If the count registers are written while the timer runs, the current cycle is not affected. The new value is used at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle enable from the slow time base |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| tc | output | 1 | Terminal-count pulse |

## Verification
Loaded values from 0 to 24 are swept in repeating mode over three periods each, and every tick is compared with an arithmetic model. This separates an off-by-one period from a missing reload. The same values are swept in single-cycle mode, including a restart, which separates pulse placement from self-clear timing. Values with high bits set (256 and 8191) exercise the upper count register. Directed cases cover stopping mid-count, stopping during the pulse, a write that collides with the self-clear, a reload value changed mid-count, and long idle gaps between ticks.

// File: rtl/rtimer_pkg.sv
package rtimer_pkg;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_LOW  = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_HIGH = 2'd2;

  localparam int unsigned BIT_RUN  = 0;
  localparam int unsigned BIT_ONCE = 1;

  typedef struct packed {
    logic once;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/rtimer_rdmux.sv
module rtimer_rdmux
  import rtimer_pkg::*;
#(
  parameter int unsigned CNT_W = 13,
  localparam int unsigned HI_W = CNT_W - BUS_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  ctrl_t             ctrl_i,
  input  logic [BUS_W-1:0]  lo_i,
  input  logic [HI_W-1:0]   hi_i,
  output logic [BUS_W-1:0]  rdata_o
);
  logic [BUS_W-1:0] hi_ext;
  logic [BUS_W-1:0] ctrl_ext;

  generate
    if (HI_W < BUS_W) begin : g_pad_hi
      assign hi_ext = {{(BUS_W-HI_W){1'b0}}, hi_i};
    end else begin : g_full_hi
      assign hi_ext = hi_i[BUS_W-1:0];
    end
  endgenerate

  always_comb begin
    ctrl_ext           = '0;
    ctrl_ext[BIT_RUN]  = ctrl_i.run;
    ctrl_ext[BIT_ONCE] = ctrl_i.once;
  end

  always_comb begin
    unique case (addr_i)
      ADR_CTRL: rdata_o = ctrl_ext;
      ADR_LOW:  rdata_o = lo_i;
      ADR_HIGH: rdata_o = hi_ext;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rtimer_regs.sv
module rtimer_regs
  import rtimer_pkg::*;
#(
  parameter int unsigned CNT_W = 13,
  localparam int unsigned HI_W = CNT_W - BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              done_i,
  output ctrl_t             ctrl_o,
  output logic              kill_o,
  output logic [BUS_W-1:0]  lo_o,
  output logic [HI_W-1:0]   hi_o,
  output logic [CNT_W-1:0]  reload_o
);
  ctrl_t            ctrl_q, ctrl_d;
  logic [BUS_W-1:0] lo_q, lo_d;
  logic [HI_W-1:0]  hi_q, hi_d;
  logic             ctrl_wr, lo_wr, hi_wr;

  assign ctrl_wr = wr_i && (addr_i == ADR_CTRL);
  assign lo_wr   = wr_i && (addr_i == ADR_LOW);
  assign hi_wr   = wr_i && (addr_i == ADR_HIGH);

  always_comb begin
    ctrl_d = ctrl_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    if (done_i) ctrl_d.run = 1'b0;
    if (ctrl_wr) begin
      ctrl_d.run  = wdata_i[BIT_RUN];
      ctrl_d.once = wdata_i[BIT_ONCE];
    end
    if (lo_wr) lo_d = wdata_i;
    if (hi_wr) hi_d = wdata_i[HI_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign kill_o   = ctrl_wr && !wdata_i[BIT_RUN];
  assign lo_o     = lo_q;
  assign hi_o     = hi_q;
  assign reload_o = {hi_q, lo_q};

  // R7: completion without a bus write clears the run bit
  p_selfclear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !ctrl_wr) |=> !ctrl_q.run);

  // R10: a bus write of run=1 wins over the self-clear
  p_sw_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && ctrl_wr && wdata_i[BIT_RUN]) |=> ctrl_q.run);
endmodule

// File: rtl/rtimer_core.sv
module rtimer_core #(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             once_i,
  input  logic             kill_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             tc_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             tc_q, tc_d;
  logic             at_zero, active;

  assign at_zero = (cnt_q == '0);
  assign active  = run_i && !kill_i;
  assign done_o  = tick_i && active && armed_q && at_zero && once_i;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    tc_d    = tc_q;
    if (!active) begin
      armed_d = 1'b0;
      tc_d    = 1'b0;
    end else if (tick_i) begin
      if (!armed_q) begin
        cnt_d   = reload_i;
        armed_d = 1'b1;
        tc_d    = (reload_i == '0);
      end else if (at_zero) begin
        if (once_i) begin
          armed_d = 1'b0;
          tc_d    = 1'b0;
        end else begin
          cnt_d = reload_i;
          tc_d  = (reload_i == '0);
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
        tc_d  = (cnt_q == CNT_W'(1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      tc_q    <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      tc_q    <= tc_d;
    end
  end

  assign tc_o = tc_q;

  // R4: the count holds between ticks
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));

  // R4: a running, nonzero count steps down by one per tick
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && active && armed_q && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R5: the pulse is only ever high while the count sits at zero
  p_tc_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q |-> at_zero);

  // R6: repeating mode reloads on the tick after zero
  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && active && armed_q && at_zero && !once_i) |=> (cnt_q == $past(reload_i)));

  // R9: a stopped timer never shows a pulse
  p_tc_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q |-> run_i);
endmodule

// File: rtl/rtimer_top.sv
module rtimer_top
  import rtimer_pkg::*;
#(
  parameter int unsigned CNT_W = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        tc
);
  localparam int unsigned HI_W = CNT_W - BUS_W;

  ctrl_t            ctrl;
  logic             kill, done;
  logic [BUS_W-1:0] lo;
  logic [HI_W-1:0]  hi;
  logic [CNT_W-1:0] reload;

  rtimer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_i   (bus_addr),
    .wr_i     (bus_wr),
    .wdata_i  (bus_wdata),
    .done_i   (done),
    .ctrl_o   (ctrl),
    .kill_o   (kill),
    .lo_o     (lo),
    .hi_o     (hi),
    .reload_o (reload)
  );

  rtimer_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick),
    .run_i    (ctrl.run),
    .once_i   (ctrl.once),
    .kill_i   (kill),
    .reload_i (reload),
    .tc_o     (tc),
    .done_o   (done)
  );

  rtimer_rdmux #(.CNT_W(CNT_W)) u_rdmux (
    .addr_i  (bus_addr),
    .ctrl_i  (ctrl),
    .lo_i    (lo),
    .hi_i    (hi),
    .rdata_o (bus_rdata)
  );
endmodule

// File: tb/sim_rtimer_top.sv
module sim_rtimer_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic [1:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       tc;

  int total = 0;
  int bad   = 0;

  rtimer_top u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tc(tc)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic tk);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; tick = tk;
    @(negedge clk);
    bus_wr = 1'b0; tick = 1'b0; bus_addr = 2'd0; bus_wdata = 8'd0;
  endtask

  task automatic bus_read(input logic [1:0] a, output int v);
    @(negedge clk);
    bus_addr = a;
    #1 v = int'(bus_rdata);
    bus_addr = 2'd0;
  endtask

  task automatic step;
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_count(input int n);
    bus_write(2'd1, 8'(n & 255), 1'b0);
    bus_write(2'd2, 8'((n >> 8) & 31), 1'b0);
  endtask

  task automatic run_repeat(input int n, input int periods);
    set_count(n);
    bus_write(2'd0, 8'h01, 1'b0);
    for (int t = 0; t < periods * (n + 1); t++) begin
      step();
      if (t == 0)          chk("R3 load tick", int'(tc), (n == 0) ? 1 : 0);
      else if (n == 0)     chk("R11 zero count", int'(tc), 1);
      else if (t > n)      chk("R6 reload period", int'(tc), ((n - (t % (n + 1))) == 0) ? 1 : 0);
      else                 chk("R5 pulse place", int'(tc), (t == n) ? 1 : 0);
    end
    bus_write(2'd0, 8'h00, 1'b0);
    chk("R9 stop", int'(tc), 0);
  endtask

  task automatic run_once(input int n, input string req);
    int v;
    bus_write(2'd0, 8'h03, 1'b0);
    for (int t = 0; t <= n + 3; t++) begin
      step();
      chk(req, int'(tc), (t == n) ? 1 : 0);
    end
    bus_read(2'd0, v);
    chk("R7 run bit cleared", v, 2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v;
    rst_n = 1'b0; tick = 1'b0; bus_addr = 2'd0; bus_wr = 1'b0; bus_wdata = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      bus_read(2'(a), v);
      chk("R1 reset read", v, 0);
    end
    chk("R1 reset tc", int'(tc), 0);

    // R2 register map
    bus_write(2'd0, 8'hFE, 1'b0); bus_read(2'd0, v); chk("R2 ctrl bits", v, 2);
    bus_write(2'd0, 8'h00, 1'b0);
    bus_write(2'd1, 8'hA5, 1'b0); bus_read(2'd1, v); chk("R2 low byte", v, 8'hA5);
    bus_write(2'd2, 8'hFF, 1'b0); bus_read(2'd2, v); chk("R2 high bits", v, 8'h1F);
    bus_write(2'd3, 8'hFF, 1'b0); bus_read(2'd3, v); chk("R2 unused addr", v, 0);
    bus_read(2'd0, v); chk("R2 ctrl untouched", v, 0);

    // R3 R5 R6 R11 repeating sweep
    for (int n = 0; n <= 24; n++) run_repeat(n, 3);
    run_repeat(256, 2);

    // R7 R8 single-cycle sweep with restart
    for (int n = 0; n <= 24; n++) begin
      set_count(n);
      run_once(n, "R7 single cycle");
      run_once(n, "R8 restart");
    end
    set_count(8191);
    run_once(8191, "R7 full width");
    bus_write(2'd0, 8'h00, 1'b0);

    // R4 hold between ticks
    set_count(1);
    bus_write(2'd0, 8'h01, 1'b0);
    step(); chk("R4 load", int'(tc), 0);
    repeat (30) @(negedge clk);
    chk("R4 hold low", int'(tc), 0);
    step(); chk("R4 pulse", int'(tc), 1);
    repeat (30) @(negedge clk);
    chk("R4 hold high", int'(tc), 1);
    step(); chk("R4 after pulse", int'(tc), 0);
    bus_write(2'd0, 8'h00, 1'b0);

    // R9 stop mid-count and during pulse
    set_count(5);
    bus_write(2'd0, 8'h01, 1'b0);
    repeat (3) step();
    bus_write(2'd0, 8'h00, 1'b0);
    for (int k = 0; k < 10; k++) begin
      step(); chk("R9 stays stopped", int'(tc), 0);
    end
    set_count(2);
    bus_write(2'd0, 8'h01, 1'b0);
    repeat (3) step();
    chk("R9 pulse before stop", int'(tc), 1);
    bus_write(2'd0, 8'h00, 1'b0);
    chk("R9 immediate low", int'(tc), 0);

    // R10 collision of self-clear and bus write
    bus_write(2'd0, 8'h03, 1'b0);
    repeat (3) step();
    chk("R10 pulse", int'(tc), 1);
    bus_write(2'd0, 8'h03, 1'b1);
    bus_read(2'd0, v); chk("R10 run kept", v, 3);
    chk("R10 low after", int'(tc), 0);
    step(); chk("R10 reload", int'(tc), 0);
    step(); chk("R10 count", int'(tc), 0);
    step(); chk("R10 second pulse", int'(tc), 1);
    bus_write(2'd0, 8'h00, 1'b0);

    // R12 reload value change mid-count
    set_count(3);
    bus_write(2'd0, 8'h01, 1'b0);
    step(); step();
    set_count(5);
    for (int t = 2; t <= 9; t++) begin
      step();
      chk("R12 new value at reload", int'(tc), (t == 3 || t == 9) ? 1 : 0);
    end
    bus_write(2'd0, 8'h00, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule